// File: doc/BRIEF.md
# Multi-Fault Response Checker

This block grades a group of injected faults during a hardware emulation run. Each clock cycle that carries a test vector, it compares the observed primary outputs of the circuit against the good response for that vector. The good responses sit in a small on-block memory. Several faults may be active in one session, provided no two of them can reach the same output. Each fault slot owns an output-mask register naming the outputs its fault can reach. Any output that differs from the stored value is credited to the one slot whose mask covers it. Each slot keeps a sticky detected flag.

Before a session, software-side logic loads the good responses through a write port and programs one mask per slot. A start pulse clears all flags and begins the session. The session then consumes exactly `DEPTH` valid vectors; cycles without a valid vector are skipped. After the final compare, a one-cycle done pulse marks the cycle in which the per-slot detected vector and the error flag hold the session result. A mismatch on an output that no mask covers raises the error flag instead of crediting a slot. A start request is refused while any two masks share an output, because one fault could then hide the other.

Top module: `fault_resp_checker`

## Requirements
- R1: While reset is low, `busy_o`, `done_o`, `err_o` and every bit of `det_o` are 0.
- R2: During a session, each cycle with `vec_valid_i` high makes one compare of `obs_i` against the stored response at the next vector index, starting at index 0. Cycles with `vec_valid_i` low make no compare and do not advance the index; `busy_o` stays 1 through them.
- R3: A compared bit where `obs_i` differs from the stored response, and that bit is set in the mask of slot s, sets `det_o[s]` and no other slot's flag.
- R4: Detected flags and `err_o` are sticky for the rest of the session. An accepted start clears them, so one cycle after the start `busy_o` is 1 and `det_o` and `err_o` are 0.
- R5: A differing bit that lies outside the union of all masks sets `err_o` and credits no slot.
- R6: `done_o` is 1 for exactly one cycle, the cycle after the `DEPTH`-th compare. In that cycle `busy_o` is 0, and `det_o` and `err_o` hold the session result, which stays until the next accepted start.
- R7: A start pulse while any two slot masks have a common bit set is ignored: no session begins and `busy_o` stays 0.
- R8: Writes to the response memory and to the mask registers are ignored while `busy_o` is 1. The stored responses and the masks used by the session are unchanged.
- R9: A start that arrives in the same cycle as `done_o` leaves that cycle's result visible on `det_o` and `err_o`. The new session begins on the next cycle with its flags cleared.
- R10: A `vec_valid_i` pulse while no session is running is ignored. `det_o` and `err_o` keep their values, and no `done_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_we | input | 1 | Response memory write enable |
| mem_addr | input | AW | Response memory write address (vector index) |
| mem_data | input | N_OUT | Good response to store |
| mask_we | input | 1 | Mask register write enable |
| mask_slot | input | SW | Slot whose mask is written |
| mask_data | input | N_OUT | Output-reach mask for that slot |
| start_i | input | 1 | Session start pulse |
| vec_valid_i | input | 1 | A test vector's response is present on obs_i |
| obs_i | input | N_OUT | Observed primary outputs |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle pulse after the last compare |
| det_o | output | N_SLOT | Per-slot sticky detected flags |
| err_o | output | 1 | Mismatch seen on an output outside every mask |

## Verification
The closing report of one session and the start of the next can share a cycle. The bench provokes this by raising `start_i` in the very cycle that `done_o` is high. In that cycle the scoreboard monitor pops the expected result and compares it against `det_o` and `err_o`. One cycle later the driver requires `busy_o` high and every flag cleared. Mid-session memory and mask writes, idle valid pulses and vector gaps are judged in the same way at the ports.

// File: rtl/frc_pkg.sv
package frc_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } frc_seq_e;
endpackage

// File: rtl/frc_resp_mem.sv
module frc_resp_mem #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/frc_sequencer.sv
module frc_sequencer
   import frc_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_acc,
   input  logic          vec_valid,
   output logic          busy,
   output logic          cmp_en,
   output logic [AW-1:0] idx,
   output logic          done
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   frc_seq_e state;

   assign busy   = (state == SEQ_RUN);
   assign cmp_en = busy & vec_valid & ~start_acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         idx   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start_acc) begin
            state <= SEQ_RUN;
            idx   <= '0;
         end else if (cmp_en) begin
            if (idx == LAST) begin
               state <= SEQ_IDLE;
               idx   <= '0;
               done  <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/frc_slot.sv
module frc_slot #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_wr,
   input  logic [WIDTH-1:0] mask_data,
   input  logic             clear,
   input  logic             cmp_en,
   input  logic [WIDTH-1:0] mism,
   output logic [WIDTH-1:0] mask_q,
   output logic             det
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         det    <= 1'b0;
      end else begin
         if (mask_wr) mask_q <= mask_data;
         if (clear) det <= 1'b0;
         else if (cmp_en && |(mism & mask_q)) det <= 1'b1;
      end
   end
endmodule

// File: rtl/fault_resp_checker.sv
module fault_resp_checker #(
   parameter int N_OUT  = 8,
   parameter int N_SLOT = 4,
   parameter int DEPTH  = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int SW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_we,
   input  logic [AW-1:0]     mem_addr,
   input  logic [N_OUT-1:0]  mem_data,
   input  logic              mask_we,
   input  logic [SW-1:0]     mask_slot,
   input  logic [N_OUT-1:0]  mask_data,
   input  logic              start_i,
   input  logic              vec_valid_i,
   input  logic [N_OUT-1:0]  obs_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [N_SLOT-1:0] det_o,
   output logic              err_o
);
   if (N_OUT < 1) begin : g_bad_width
      $error("N_OUT must be at least 1");
   end
   if (N_SLOT < 1) begin : g_bad_slots
      $error("N_SLOT must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [AW-1:0]    idx;
   logic [N_OUT-1:0] good_rd;
   logic [N_OUT-1:0] mism;
   logic [N_OUT-1:0] mask_q [N_SLOT];
   logic [N_OUT-1:0] covered;
   logic [N_SLOT*N_SLOT-1:0] pair_hit;
   logic             clash;
   logic             start_acc;
   logic             cmp_en;
   logic             mem_we_g;
   logic             mask_we_g;

   assign mem_we_g  = mem_we & ~busy_o;
   assign mask_we_g = mask_we & ~busy_o;
   assign clash     = |pair_hit;
   assign start_acc = start_i & ~clash;
   assign mism      = obs_i ^ good_rd;

   frc_resp_mem #(.WIDTH(N_OUT), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (mem_we_g),
      .waddr (mem_addr),
      .wdata (mem_data),
      .raddr (idx),
      .rdata (good_rd)
   );

   frc_sequencer #(.DEPTH(DEPTH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_acc (start_acc),
      .vec_valid (vec_valid_i),
      .busy      (busy_o),
      .cmp_en    (cmp_en),
      .idx       (idx),
      .done      (done_o)
   );

   for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      frc_slot #(.WIDTH(N_OUT)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .mask_wr   (mask_we_g && (mask_slot == SW'(s))),
         .mask_data (mask_data),
         .clear     (start_acc),
         .cmp_en    (cmp_en),
         .mism      (mism),
         .mask_q    (mask_q[s]),
         .det       (det_o[s])
      );
   end

   for (genvar i = 0; i < N_SLOT; i++) begin : g_pair_row
      for (genvar j = 0; j < N_SLOT; j++) begin : g_pair_col
         if (j > i) begin : g_cmp
            assign pair_hit[i*N_SLOT+j] = |(mask_q[i] & mask_q[j]);
         end else begin : g_none
            assign pair_hit[i*N_SLOT+j] = 1'b0;
         end
      end
   end

   always_comb begin
      covered = '0;
      for (int s = 0; s < N_SLOT; s++) covered = covered | mask_q[s];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_o <= 1'b0;
      end else if (start_acc) begin
         err_o <= 1'b0;
      end else if (cmp_en && |(mism & ~covered)) begin
         err_o <= 1'b1;
      end
   end
endmodule

// File: rtl/fault_resp_checker_sva.sv
module fault_resp_checker_sva #(
   parameter int N_SLOT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              start_acc,
   input logic              busy_o,
   input logic              done_o,
   input logic [N_SLOT-1:0] det_o,
   input logic              err_o
);
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r6_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(busy_o) && !busy_o));

   a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_acc |=> (busy_o && det_o == '0 && !err_o));

   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> ((det_o & $past(det_o)) == $past(det_o)));

   a_r7_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !start_acc && !busy_o) |=> !busy_o);

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(det_o) && $stable(err_o) && !busy_o));

   a_r5_err_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(busy_o));
endmodule

bind fault_resp_checker fault_resp_checker_sva #(.N_SLOT(N_SLOT)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .start_acc (start_acc),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .det_o     (det_o),
   .err_o     (err_o)
);

// File: tb/fault_resp_checker_tb.sv
`timescale 1ns/1ps
module fault_resp_checker_tb;
   localparam int N_OUT  = 8;
   localparam int N_SLOT = 4;
   localparam int DEPTH  = 16;
   localparam int AW = $clog2(DEPTH);
   localparam int SW = $clog2(N_SLOT);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mem_we = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [N_OUT-1:0] mem_data = '0;
   logic mask_we = 1'b0;
   logic [SW-1:0] mask_slot = '0;
   logic [N_OUT-1:0] mask_data = '0;
   logic start_i = 1'b0;
   logic vec_valid_i = 1'b0;
   logic [N_OUT-1:0] obs_i = '0;
   logic busy_o, done_o, err_o;
   logic [N_SLOT-1:0] det_o;

   always #2.5 clk = ~clk;

   fault_resp_checker #(.N_OUT(N_OUT), .N_SLOT(N_SLOT), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_data(mem_data), .mask_we(mask_we), .mask_slot(mask_slot),
      .mask_data(mask_data), .start_i(start_i), .vec_valid_i(vec_valid_i),
      .obs_i(obs_i), .busy_o(busy_o), .done_o(done_o), .det_o(det_o),
      .err_o(err_o)
   );

   typedef struct packed {
      logic [N_SLOT-1:0] det;
      logic              err;
   } exp_t;

   exp_t sb_q[$];
   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [N_OUT-1:0] mem_m  [DEPTH];
   logic [N_OUT-1:0] mask_m [N_SLOT];
   logic [N_OUT-1:0] flip   [DEPTH];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // monitor: pops the expected result whenever a session reports
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sb_q.size() == 0) begin
            chk(0, "R6 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(det_o == e.det, "R3 det at done", 32'(det_o), 32'(e.det));
            chk(err_o == e.err, "R5 err at done", 32'(err_o), 32'(e.err));
            chk(busy_o == 1'b0, "R6 busy low at done", 32'(busy_o), 0);
         end
      end
   end

   task automatic wr_mem(input int a, input logic [N_OUT-1:0] d);
      mem_we = 1; mem_addr = AW'(a); mem_data = d;
      @(negedge clk);
      mem_we = 0;
   endtask

   task automatic wr_mask(input int s, input logic [N_OUT-1:0] m);
      mask_we = 1; mask_slot = SW'(s); mask_data = m;
      @(negedge clk);
      mask_we = 0;
   endtask

   task automatic clear_flips();
      for (int k = 0; k < DEPTH; k++) flip[k] = '0;
   endtask

   // driver: runs one session, pushes the expected result, returns at the done cycle
   task automatic do_session(input bit gaps, input bit wr_mid);
      exp_t e;
      logic [N_OUT-1:0] un;
      un = '0;
      for (int s = 0; s < N_SLOT; s++) un = un | mask_m[s];
      e = '0;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      chk(busy_o == 1'b1, "R4 busy after start", 32'(busy_o), 1);
      chk(det_o == '0, "R4 det cleared", 32'(det_o), 0);
      chk(err_o == 1'b0, "R4 err cleared", 32'(err_o), 0);
      for (int k = 0; k < DEPTH; k++) begin
         vec_valid_i = 1;
         obs_i = mem_m[k] ^ flip[k];
         for (int s = 0; s < N_SLOT; s++)
            if ((flip[k] & mask_m[s]) != '0) e.det[s] = 1'b1;
         if ((flip[k] & ~un) != '0) e.err = 1'b1;
         if (wr_mid && k == 4) begin
            mem_we = 1; mem_addr = AW'(DEPTH-1); mem_data = ~mem_m[DEPTH-1];
            mask_we = 1; mask_slot = '0; mask_data = '1;
         end
         if (k == DEPTH-1) sb_q.push_back(e);
         @(negedge clk);
         vec_valid_i = 0; mem_we = 0; mask_we = 0;
         if (gaps && k != DEPTH-1) begin
            @(negedge clk);
            chk(busy_o == 1'b1, "R2 busy through gap", 32'(busy_o), 1);
            chk(done_o == 1'b0, "R2 no early done", 32'(done_o), 0);
         end
      end
      chk(done_o == 1'b1, "R6 done after last compare", 32'(done_o), 1);
   endtask

   initial begin
      #(5.0 * 150000);
      chk(0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      logic [N_SLOT-1:0] keep_det;
      logic keep_err;
      clear_flips();
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && done_o == 0, "R1 busy/done in reset", {busy_o, done_o}, 0);
      chk(det_o == '0, "R1 det in reset", 32'(det_o), 0);
      chk(err_o == 0, "R1 err in reset", 32'(err_o), 0);
      rst_n = 1;
      @(negedge clk);

      for (int k = 0; k < DEPTH; k++) begin
         mem_m[k] = N_OUT'(k * 37 + 5);
         wr_mem(k, mem_m[k]);
      end
      mask_m[0] = 8'h03; mask_m[1] = 8'h0C; mask_m[2] = 8'h30; mask_m[3] = 8'h40;
      for (int s = 0; s < N_SLOT; s++) wr_mask(s, mask_m[s]);

      // R2 R6: clean session, no detection
      do_session(0, 0); @(negedge clk);
      chk(done_o == 0, "R6 done one cycle", 32'(done_o), 0);

      // R3: one bit in slot 1's mask
      clear_flips(); flip[5] = 8'h04;
      do_session(0, 0); @(negedge clk);
      chk(det_o == 4'b0010, "R6 result held", 32'(det_o), 32'h2);

      // R4 R5: repeated slot-0 hit, slot-2 hit, and uncovered bit 7
      clear_flips(); flip[1] = 8'h01; flip[9] = 8'h02; flip[12] = 8'h20; flip[14] = 8'h80;
      do_session(0, 0); @(negedge clk);

      // R10: valid pulses while idle change nothing
      keep_det = det_o; keep_err = err_o;
      for (int k = 0; k < 3; k++) begin
         vec_valid_i = 1; obs_i = ~mem_m[k];
         @(negedge clk);
      end
      vec_valid_i = 0;
      @(negedge clk);
      chk(det_o == keep_det, "R10 det held idle", 32'(det_o), 32'(keep_det));
      chk(err_o == keep_err, "R10 err held idle", 32'(err_o), 32'(keep_err));
      chk(busy_o == 0, "R10 no session", 32'(busy_o), 0);

      // R2: gaps between vectors
      clear_flips(); flip[DEPTH-1] = 8'h40;
      do_session(1, 0); @(negedge clk);

      // R8: writes during a session are ignored
      clear_flips(); flip[10] = 8'h80;
      do_session(0, 1); @(negedge clk);

      // R7: overlapping masks refuse start
      wr_mask(3, 8'h41);
      start_i = 1; @(negedge clk); start_i = 0;
      chk(busy_o == 0, "R7 start refused", 32'(busy_o), 0);
      for (int k = 0; k < DEPTH + 2; k++) begin
         vec_valid_i = 1; obs_i = mem_m[k % DEPTH]; @(negedge clk);
      end
      vec_valid_i = 0;
      chk(busy_o == 0, "R7 still idle", 32'(busy_o), 0);
      wr_mask(3, mask_m[3]);

      // R9: start in the done cycle
      clear_flips(); flip[3] = 8'h10;
      do_session(0, 0);
      chk(det_o == 4'b0100, "R9 result visible with start", 32'(det_o), 32'h4);
      clear_flips();
      do_session(0, 0); @(negedge clk);

      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R6 every session reported", sb_q.size(), 0);
      summary();
   end
endmodule